// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Sequencer

This block is one DMA channel that moves 32-bit words between main memory and one peripheral. Software programs three registers (a start address, a block control and a channel control) through a small register port, then sets the busy bit. The channel runs one of three transfer styles. The first is an immediate burst of a fixed number of words. The second is a series of equal blocks, each paced by a request line from the peripheral. The third is a walk through a linked list of nodes in memory. Completion clears the busy bit and fires a one-cycle done pulse.

Memory is reached through a word-wide request/acknowledge port. An external arbiter owns a grant input, and that input gates every memory request. Peripheral words leave on a valid/ready pair and arrive on a valid/take pair. Writing the control register with busy clear while a transfer runs stops the transfer at the next word boundary.

Register selects on `regSel`: 0 is the address, 1 is the block control and 2 is the channel control. Any other value reads as zero.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset all three registers read zero, `memReq` is low and `donePulse` is low.
- R2: The address register keeps 24 bits. Bits 31..24 read as zero, and bits 1..0 read back as written. Every address the engine issues or writes back has bits 1..0 at zero.
- R3: With mode bits 10..9 = 0, a transfer starts only when busy (bit 24) and trigger (bit 28) are both set. With busy alone the channel stays armed, busy reads 1, and no word moves.
- R4: The trigger bit reads 0 once a transfer has begun. Busy clears on completion, and `donePulse` is high for exactly one cycle, the first cycle in which busy reads 0.
- R5: Mode 0 moves block bits 15..0 words, where 0 means 65536. The address and block registers are not changed by the transfer.
- R6: Control bit 0 = 1 reads words from memory and presents them on `perTxData`. Bit 0 = 0 takes words from `perRxData` and writes them to memory.
- R7: Control bit 1 = 0 steps the address by +4 per word, and bit 1 = 1 steps it by -4.
- R8: Mode 1 moves block bits 31..16 blocks of block bits 15..0 words each. Each block starts only while `perDrq` is high. After each block the count field drops by one and the address register holds the next block's address. At the end the count field is 0 and the address register holds the end address.
- R9: Mode 2 always reads memory. Each node header has bits 23..0 = next node address and bits 31..24 = payload word count. Headers are not forwarded; only payload words are. The walk ends after a node whose next address has bit 23 set, and the address register then holds that marker with bits 1..0 cleared.
- R10: `memReq` is never high while `grant` is low.
- R11: Writing the control register with bit 24 clear during a transfer ends it at the next word boundary, clearing busy with a done pulse.
- R12: While a transfer runs, writes to the address and block registers are ignored, and so are control writes to every field except busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 address, 1 block, 2 control) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regSel` |
| grant | input | 1 | Arbiter grant; gates memory requests |
| memReq | output | 1 | Memory word request |
| memWr | output | 1 | Request is a write |
| memAddr | output | 24 | Word-aligned byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory accepts the request this cycle |
| perDrq | input | 1 | Peripheral block request (mode 1) |
| perTxValid | output | 1 | Word offered to the peripheral |
| perTxData | output | 32 | Word to the peripheral |
| perTxReady | input | 1 | Peripheral accepts the word |
| perRxValid | input | 1 | Peripheral offers a word |
| perRxData | input | 32 | Word from the peripheral |
| perRxTake | output | 1 | Engine takes the offered word |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after these corner cases:

- **Trigger gate.** A mode 0 channel armed with busy alone must stay still. A design that ignored the trigger would start at once and move words early.
- **Count of zero.** A count field of zero must mean a long transfer. A design that read zero literally would finish at once or never move a word.
- **Linked-list walk.** The bench walks a list whose middle node carries no payload and ends on a marker with its low bits set. A design that forwarded headers, stalled on the empty node or skipped the alignment would show the wrong word stream or the wrong final address.
- **Grant and request gating.** Grant is held low and the block request is withheld before the transfer may move. A design that ignored either would move words too early.
- **Abort and ignored writes.** A run is aborted, and register writes are made during it. A design that honoured those writes would read back changed fields.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    MODE_BURST  = 2'd0,
    MODE_SLICED = 2'd1,
    MODE_LIST   = 2'd2,
    MODE_RSVD   = 2'd3
  } syncMode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITREQ, ST_HEAD, ST_FETCH, ST_SEND, ST_TAKE, ST_STORE
  } engState_e;

  // control fields extracted from a register write
  typedef struct packed {
    logic      trig;
    logic      busy;
    syncMode_e mode;
    logic      step;
    logic      dir;
  } ctlFields_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic start;
    logic stepAddr;
    logic blockEnd;
    logic headLoad;
    logic nodeJump;
    logic latchMem;
    logic latchPer;
  } dpStrobe_t;
endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic          stepBack,
  input  logic          running,
  input  logic          regWrEn,
  input  logic [1:0]    regSel,
  input  logic [DW-1:0] regWrData,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] perRxData,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] blkQ,
  output logic [AW-1:0] curQ,
  output logic [DW-1:0] dataQ,
  output logic          lastWord,
  output logic          lastBlock,
  output logic          headEmpty,
  output logic          markerHit
);
  localparam int CW = DW / 2;   // width of a count field
  localparam int HC = DW - AW;  // width of the header payload count

  logic [AW-1:0] nextQ, curStep;
  logic [CW:0]   wordCnt, blkWords;

  always_comb begin
    curStep  = stepBack ? curQ - AW'(4) : curQ + AW'(4);
    blkWords = (blkQ[CW-1:0] == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, blkQ[CW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; blkQ <= '0; curQ <= '0; nextQ <= '0;
      dataQ <= '0; wordCnt <= '0;
    end else begin
      if (!running && regWrEn) begin
        if (regSel == 2'd0) addrQ <= regWrData[AW-1:0];
        if (regSel == 2'd1) blkQ  <= regWrData;
      end
      if (strb.start) begin
        curQ    <= {addrQ[AW-1:2], 2'b00};
        wordCnt <= blkWords;
      end
      if (strb.latchMem) dataQ <= memRdData;
      if (strb.latchPer) dataQ <= perRxData;
      if (strb.headLoad) begin
        nextQ   <= memRdData[AW-1:0];
        wordCnt <= {{(CW+1-HC){1'b0}}, memRdData[DW-1:AW]};
        curQ    <= curStep;
      end
      if (strb.stepAddr) begin
        curQ    <= curStep;
        wordCnt <= wordCnt - (CW+1)'(1);
      end
      if (strb.blockEnd) begin
        addrQ          <= {curStep[AW-1:2], 2'b00};
        blkQ[DW-1:CW]  <= blkQ[DW-1:CW] - (DW-CW)'(1);
        wordCnt        <= blkWords;
      end
      if (strb.nodeJump) begin
        addrQ <= {nextQ[AW-1:2], 2'b00};
        curQ  <= {nextQ[AW-1:2], 2'b00};
      end
    end
  end

  assign lastWord  = (wordCnt == (CW+1)'(1));
  assign headEmpty = (wordCnt == '0);
  assign lastBlock = (blkQ[DW-1:CW] == (DW-CW)'(1));
  assign markerHit = nextQ[AW-1];
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWrEn,
  input  ctlFields_t    ctlIn,
  input  logic          grant,
  input  logic          memAck,
  input  logic          perDrq,
  input  logic          perTxReady,
  input  logic          perRxValid,
  input  logic          lastWord,
  input  logic          lastBlock,
  input  logic          headEmpty,
  input  logic          markerHit,
  output dpStrobe_t     strb,
  output logic [DW-1:0] ctlWord,
  output logic          running,
  output logic          busyQ,
  output logic          stepQ,
  output syncMode_e     modeQ,
  output logic          memReq,
  output logic          memWr,
  output logic          perTxValid,
  output logic          perRxTake,
  output logic          donePulse
);
  engState_e state, stNext, firstSt, nextWordSt;
  logic dirQ, trigQ, abortQ, finish, wordDone;

  assign running = (state != ST_IDLE);
  assign ctlWord = {3'b0, trigQ, 3'b0, busyQ, 13'b0, modeQ, 7'b0, stepQ, dirQ};

  always_comb begin
    strb = '0; stNext = state; finish = 1'b0; wordDone = 1'b0;
    memReq = 1'b0; memWr = 1'b0; perTxValid = 1'b0; perRxTake = 1'b0;
    firstSt    = dirQ ? ST_FETCH : ST_TAKE;
    nextWordSt = (modeQ == MODE_LIST) ? ST_FETCH : firstSt;
    case (state)
      ST_IDLE:
        if (busyQ && (modeQ == MODE_SLICED || modeQ == MODE_LIST ||
                      (modeQ == MODE_BURST && trigQ))) begin
          strb.start = 1'b1;
          stNext = (modeQ == MODE_BURST)  ? firstSt :
                   (modeQ == MODE_SLICED) ? ST_WAITREQ : ST_HEAD;
        end
      ST_WAITREQ:
        if (abortQ) finish = 1'b1;
        else if (perDrq) stNext = firstSt;
      ST_HEAD: begin
        memReq = grant;
        if (grant && memAck) begin
          strb.headLoad = 1'b1;
          stNext = ST_FETCH;
        end
      end
      ST_FETCH:
        if (headEmpty) begin
          strb.nodeJump = 1'b1;
          if (markerHit || abortQ) finish = 1'b1;
          else stNext = ST_HEAD;
        end else begin
          memReq = grant;
          if (grant && memAck) begin
            strb.latchMem = 1'b1;
            stNext = ST_SEND;
          end
        end
      ST_SEND: begin
        perTxValid = 1'b1;
        wordDone   = perTxReady;
      end
      ST_TAKE:
        if (abortQ) finish = 1'b1;
        else if (perRxValid) begin
          perRxTake = 1'b1;
          strb.latchPer = 1'b1;
          stNext = ST_STORE;
        end
      ST_STORE: begin
        memReq = grant;
        memWr  = grant;
        wordDone = grant && memAck;
      end
      default: stNext = ST_IDLE;
    endcase

    if (wordDone) begin
      strb.stepAddr = 1'b1;
      if (modeQ == MODE_LIST) begin
        if (lastWord) begin
          strb.nodeJump = 1'b1;
          if (markerHit || abortQ) finish = 1'b1;
          else stNext = ST_HEAD;
        end else if (abortQ) finish = 1'b1;
        else stNext = nextWordSt;
      end else if (!lastWord) begin
        if (abortQ) finish = 1'b1;
        else stNext = nextWordSt;
      end else if (modeQ == MODE_SLICED) begin
        strb.blockEnd = 1'b1;
        if (lastBlock || abortQ) finish = 1'b1;
        else stNext = ST_WAITREQ;
      end else finish = 1'b1;
    end
    if (finish) stNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; donePulse <= 1'b0;
      dirQ <= 1'b0; stepQ <= 1'b0; modeQ <= MODE_BURST;
      busyQ <= 1'b0; trigQ <= 1'b0; abortQ <= 1'b0;
    end else begin
      state     <= stNext;
      donePulse <= finish;
      if (finish) busyQ <= 1'b0;
      if (strb.start) begin
        trigQ  <= 1'b0;
        abortQ <= 1'b0;
      end
      if (ctlWrEn) begin
        if (!running) begin
          dirQ <= ctlIn.dir; stepQ <= ctlIn.step; modeQ <= ctlIn.mode;
          busyQ <= ctlIn.busy; trigQ <= ctlIn.trig;
        end else if (!ctlIn.busy) abortQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regSel,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          grant,
  output logic          memReq,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  input  logic [DW-1:0] memRdData,
  input  logic          memAck,
  input  logic          perDrq,
  output logic          perTxValid,
  output logic [DW-1:0] perTxData,
  input  logic          perTxReady,
  input  logic          perRxValid,
  input  logic [DW-1:0] perRxData,
  output logic          perRxTake,
  output logic          donePulse
);
  dpStrobe_t     strb;
  ctlFields_t    ctlIn;
  syncMode_e     modeQ;
  logic [DW-1:0] ctlWord, blkQ, dataQ;
  logic [AW-1:0] addrQ, curQ;
  logic running, busyNow, stepQ, lastWord, lastBlock, headEmpty, markerHit;
  logic [1:0] modeNow;

  assign ctlIn = '{trig: regWrData[28], busy: regWrData[24],
                   mode: syncMode_e'(regWrData[10:9]),
                   step: regWrData[1], dir: regWrData[0]};
  assign modeNow = modeQ;

  dma_chan_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(regWrEn && regSel == 2'd2), .ctlIn(ctlIn),
    .grant(grant), .memAck(memAck), .perDrq(perDrq), .perTxReady(perTxReady),
    .perRxValid(perRxValid), .lastWord(lastWord), .lastBlock(lastBlock),
    .headEmpty(headEmpty), .markerHit(markerHit), .strb(strb), .ctlWord(ctlWord),
    .running(running), .busyQ(busyNow), .stepQ(stepQ), .modeQ(modeQ),
    .memReq(memReq), .memWr(memWr), .perTxValid(perTxValid),
    .perRxTake(perRxTake), .donePulse(donePulse)
  );

  dma_chan_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stepBack(stepQ), .running(running),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memRdData(memRdData), .perRxData(perRxData), .addrQ(addrQ), .blkQ(blkQ),
    .curQ(curQ), .dataQ(dataQ), .lastWord(lastWord), .lastBlock(lastBlock),
    .headEmpty(headEmpty), .markerHit(markerHit)
  );

  assign memAddr   = curQ;
  assign memWrData = dataQ;
  assign perTxData = dataQ;

  always_comb
    case (regSel)
      2'd0:    regRdData = {{(DW-AW){1'b0}}, addrQ};
      2'd1:    regRdData = blkQ;
      2'd2:    regRdData = ctlWord;
      default: regRdData = '0;
    endcase
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic       clk,
  input logic       rstN,
  input logic       grant,
  input logic       memReq,
  input logic       memWr,
  input logic [1:0] addrLow,
  input logic       busyNow,
  input logic       donePulse,
  input logic [1:0] modeNow,
  input logic       regWrEn,
  input logic [1:0] regSel
);
  // R10
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> grant);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> addrLow == 2'b00);
  // R4
  done_on_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busyNow && $past(busyNow)));
  // R4
  clear_has_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyNow) && !$past(regWrEn && regSel == 2'd2)) |-> donePulse);
  // R9
  list_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && modeNow == 2'd2) |-> !memWr);
endmodule

bind dma_chan_engine dma_chan_chk u_chk (
  .clk(clk), .rstN(rstN), .grant(grant), .memReq(memReq), .memWr(memWr),
  .addrLow(memAddr[1:0]), .busyNow(busyNow), .donePulse(donePulse),
  .modeNow(modeNow), .regWrEn(regWrEn), .regSel(regSel)
);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic grant = 1'b1, memReq, memWr, memAck;
  logic [23:0] memAddr;
  logic [31:0] memWrData, memRdData, perTxData, perRxData;
  logic perDrq = 1'b1, perTxValid, perTxReady = 1'b1, perRxValid = 1'b1, perRxTake, donePulse;

  logic [31:0] mem [256];
  logic [31:0] txLog [64];
  int txCount = 0, rxCount = 0, doneCount = 0, badReq = 0;
  logic fillReq = 1'b0, pokeEn = 1'b0, clrLog = 1'b0;
  logic [7:0] pokeIdx = '0;
  logic [31:0] pokeVal = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .grant(grant),
    .memReq(memReq), .memWr(memWr), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .perDrq(perDrq),
    .perTxValid(perTxValid), .perTxData(perTxData), .perTxReady(perTxReady),
    .perRxValid(perRxValid), .perRxData(perRxData), .perRxTake(perRxTake),
    .donePulse(donePulse)
  );

  assign memAck    = memReq;
  assign memRdData = mem[memAddr[9:2]];
  assign perRxData = 32'h5000_0000 + rxCount;

  always @(posedge clk) begin
    if (fillReq) for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
    else if (pokeEn) mem[pokeIdx] <= pokeVal;
    else if (memReq && memWr) mem[memAddr[9:2]] <= memWrData;
    if (clrLog) begin txCount <= 0; rxCount <= 0; end
    else begin
      if (perTxValid && perTxReady) begin
        txLog[txCount[5:0]] <= perTxData; txCount <= txCount + 1;
      end
      if (perRxTake) rxCount <= rxCount + 1;
    end
    if (donePulse) doneCount <= doneCount + 1;
    if (memReq && !grant) badReq <= badReq + 1;
  end

  // addr, blk, ctl, count, firstIdx, lastIdx, expAddr, expBlk
  localparam logic [31:0] VEC [4][8] = '{
    '{32'h40,  32'h3,        32'h1100_0001, 3, 32'h10, 32'h12, 32'h40,  32'h3},
    '{32'h80,  32'h4,        32'h1100_0003, 4, 32'h20, 32'h1D, 32'h80,  32'h4},
    '{32'h100, 32'h0002_0003, 32'h0100_0201, 6, 32'h40, 32'h45, 32'h118, 32'h3},
    '{32'h200, 32'h0003_0002, 32'h0100_0203, 6, 32'h80, 32'h7B, 32'h1E8, 32'h2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); regSel = sel; #1 d = regRdData;
  endtask

  task automatic pulseFill();
    @(negedge clk); fillReq = 1'b1; @(negedge clk); fillReq = 1'b0;
  endtask

  task automatic poke(input logic [7:0] idx, input logic [31:0] v);
    @(negedge clk); pokeEn = 1'b1; pokeIdx = idx; pokeVal = v;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrLog = 1'b1; @(negedge clk); clrLog = 1'b0;
  endtask

  task automatic waitDone(input string tag, input int limit);
    int start = doneCount;
    int n = 0;
    while (doneCount == start && n < limit) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check({tag, " one done pulse"}, doneCount - start, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(2'd0, r); check("R1 addr", r, 0);
    regRead(2'd1, r); check("R1 blk", r, 0);
    regRead(2'd2, r); check("R1 ctl", r, 0);
    check("R1 memReq", {31'b0, memReq}, 0);
    check("R1 done", {31'b0, donePulse}, 0);
    // R2 address width
    regWrite(2'd0, 32'hFFFF_FFFF);
    regRead(2'd0, r); check("R2 addr readback", r, 32'h00FF_FFFF);
    pulseFill();

    // table: R5 R6 R7 R8 R4
    for (int v = 0; v < 4; v++) begin
      pulseClr();
      regWrite(2'd0, VEC[v][0]);
      regWrite(2'd1, VEC[v][1]);
      regWrite(2'd2, VEC[v][2]);
      waitDone("R4 table", 200);
      check("R6 word count", txCount, VEC[v][3]);
      check("R7 first word", txLog[0], 32'hA000_0000 + VEC[v][4]);
      check("R7 last word", txLog[VEC[v][3]-1], 32'hA000_0000 + VEC[v][5]);
      regRead(2'd0, r); check("R5 R8 addr after", r, VEC[v][6]);
      regRead(2'd1, r); check("R5 R8 blk after", r, VEC[v][7]);
      regRead(2'd2, r); check("R4 ctl after", r, VEC[v][2] & ~32'h1100_0000);
    end

    // R3 trigger gate
    pulseClr();
    regWrite(2'd0, 32'h40); regWrite(2'd1, 32'h2);
    regWrite(2'd2, 32'h0100_0001);
    repeat (20) @(negedge clk);
    check("R3 armed no words", txCount, 0);
    regRead(2'd2, r); check("R3 armed busy", r, 32'h0100_0001);
    regWrite(2'd2, 32'h1100_0001);
    regRead(2'd2, r); check("R4 trigger self-clear", r, 32'h0100_0001);
    waitDone("R3", 100);
    check("R3 words after trigger", txCount, 2);

    // R10 grant gating
    pulseClr();
    grant = 1'b0;
    regWrite(2'd2, 32'h1100_0001);
    repeat (20) @(negedge clk);
    check("R10 no words without grant", txCount, 0);
    check("R10 no request without grant", badReq, 0);
    grant = 1'b1;
    waitDone("R10", 100);
    check("R10 words after grant", txCount, 2);

    // R8 request pacing
    pulseClr();
    perDrq = 1'b0;
    regWrite(2'd0, 32'h100); regWrite(2'd1, 32'h0001_0002);
    regWrite(2'd2, 32'h0100_0201);
    repeat (20) @(negedge clk);
    check("R8 waits for request", txCount, 0);
    perDrq = 1'b1;
    waitDone("R8", 100);
    check("R8 words", txCount, 2);
    regRead(2'd0, r); check("R8 end addr", r, 32'h108);
    regRead(2'd1, r); check("R8 count zero", r, 32'h2);

    // R6 into memory
    pulseClr();
    regWrite(2'd0, 32'h300); regWrite(2'd1, 32'h3);
    regWrite(2'd2, 32'h1100_0000);
    waitDone("R6 rx", 100);
    check("R6 mem0", mem[8'hC0], 32'h5000_0000);
    check("R6 mem1", mem[8'hC1], 32'h5000_0001);
    check("R6 mem2", mem[8'hC2], 32'h5000_0002);
    check("R6 mem3 untouched", mem[8'hC3], 32'hA000_00C3);
    regRead(2'd0, r); check("R5 addr unchanged", r, 32'h300);

    // R9 linked list
    pulseClr();
    poke(8'h08, 32'h0200_0060); poke(8'h09, 32'hB1); poke(8'h0A, 32'hB2);
    poke(8'h18, 32'h0000_0080);
    poke(8'h20, 32'h01FF_FFFF); poke(8'h21, 32'hC1);
    regWrite(2'd0, 32'h20); regWrite(2'd2, 32'h0100_0401);
    waitDone("R9", 200);
    check("R9 payload count", txCount, 3);
    check("R9 word0", txLog[0], 32'hB1);
    check("R9 word1", txLog[1], 32'hB2);
    check("R9 word2", txLog[2], 32'hC1);
    regRead(2'd0, r); check("R9 R2 marker addr", r, 32'h00FF_FFFC);
    check("R9 header not written", mem[8'h08], 32'h0200_0060);

    // R5 zero count, R12 ignored writes, R11 abort
    pulseClr();
    regWrite(2'd0, 32'h300); regWrite(2'd1, 32'h0);
    regWrite(2'd2, 32'h1100_0000);
    repeat (400) @(negedge clk);
    regRead(2'd2, r); check("R5 zero count still busy", r, 32'h0100_0000);
    check("R5 zero count moving", {31'b0, rxCount > 150}, 1);
    regWrite(2'd0, 32'h1234_5678); regWrite(2'd1, 32'h5);
    regRead(2'd0, r); check("R12 addr write ignored", r, 32'h300);
    regRead(2'd1, r); check("R12 blk write ignored", r, 32'h0);
    regWrite(2'd2, 32'h0000_0203);
    waitDone("R11", 20);
    regRead(2'd2, r); check("R11 R12 ctl after abort", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule